// File: doc/BRIEF.md
# SPI Bit-Clock Prescaler

This block turns the core clock into the edge timing of a serial peripheral bus clock. Instead of producing a clock waveform, it emits two single-cycle strobes. One marks where SCK rises and the other marks where SCK falls, and a shift engine consumes them. The divide ratio comes from an 8-bit packed setting that can be read in one of two ways, chosen by a mode input.

The extended reading packs a 4-bit mantissa and a 3-bit power-of-two exponent, with one unused bit inside the field. The legacy reading treats the low five bits as an offset code that holds half of an even divisor.

Settings that would stop the clock or run it faster than the floor are forced up to the minimum divisor. The setting is only captured while the run input is low, so a transfer always runs at a single rate. Raising run starts the count from zero, so the first rising strobe arrives exactly one high half-period after the start.

Top module: `sck_prescaler`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both strobes are low.
- R2: While run is low, neither strobe asserts, and both are low on the cycle after run is sampled low.
- R3: In extended mode (mode = 1) the divisor is M × 2^E. M is field[3:0]. E is built from field[4] as E[0], field[6] as E[1] and field[7] as E[2]. The largest value is 1920 (field 0xDF).
- R4: In extended mode, field[5] has no effect on the divisor.
- R5: In legacy mode (mode = 0) the divisor is 2 × (field[4:0] − 16), giving 4 to 30 for codes 0x12 to 0x1F. field[7:5] has no effect.
- R6: An extended mantissa of 0, or a legacy code below 0x12, gives the minimum divisor MIN_DIV (default 4).
- R7: Any decoded divisor below MIN_DIV is raised to MIN_DIV. For example, extended field 0x01 and field 0x02 both give 4.
- R8: For a divisor D, the rise-terminated half lasts D − floor(D/2) cycles and the fall-terminated half lasts floor(D/2) cycles. The strobes alternate, rise first, and one full SCK period is D cycles.
- R9: The first rising strobe is high on the cycle after the h-th rising clock edge at which run is sampled high, where h = D − floor(D/2).
- R10: The field and mode are captured on every edge where run is low. Changes made while run is high have no effect until run drops.
- R11: Dropping run mid-period abandons the count. The next start begins again with a full high half and a rising strobe.
- R12: The two strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runEn | input | 1 | High while a transfer needs SCK edges; low holds the counter idle |
| extMode | input | 1 | 1 selects the mantissa/exponent reading, 0 selects the legacy offset code |
| prescaleField | input | 8 | Packed divide setting |
| riseStb | output | 1 | One-cycle strobe at each SCK rising edge |
| fallStb | output | 1 | One-cycle strobe at each SCK falling edge |

## Verification
A mistake in the decode shows up as a wrong strobe spacing, visible from the first rising strobe onward. A mistake in the counter or the phase bit shows up as an unequal or swapped half-period within the first SCK period. A phase bit left over from an aborted run, or a divisor register updated during a run, only appears at the next start or mid-transfer. The stimulus therefore measures the first rise, the first fall and the second rise of every run, and includes aborted runs and settings changed while running.

// File: rtl/sck_div_pkg.sv
`timescale 1ns/1ps
package sck_div_pkg;

  // Which strobe the running half-period will end with.
  typedef enum logic {
    PH_TO_RISE = 1'b0,
    PH_TO_FALL = 1'b1
  } phase_e;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic   clear;    // idle: zero the counter, capture the setting
    logic   advance;  // running: count, wrap on terminal
    phase_e phase;    // selects which half length applies
  } seq_t;

endpackage

// File: rtl/sck_div_path.sv
`timescale 1ns/1ps
module sck_div_path
  import sck_div_pkg::*;
#(
  parameter int MANT_W  = 4,
  parameter int EXP_W   = 3,
  parameter int LEG_W   = 5,
  parameter int LEG_OFS = 16,
  parameter int MIN_DIV = 4,
  localparam int FIELD_W = MANT_W + EXP_W + 1,
  localparam int MAX_EXP = (1 << EXP_W) - 1,
  localparam int DIV_W   = MANT_W + MAX_EXP
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extMode,
  input  logic [FIELD_W-1:0] field,
  input  seq_t               seq,
  output logic               terminal
);

  logic [MANT_W-1:0] mant;
  logic [EXP_W-1:0]  expo;
  logic [LEG_W-1:0]  legCode;
  logic [DIV_W-1:0]  extDiv, legDiv, rawDiv, decDiv;
  logic [DIV_W-1:0]  divReg, hiLen, loLen, curLen, cnt;
  logic              unusedHole;

  // Field decode: mantissa low, exponent split around a hole bit.
  assign mant       = field[MANT_W-1:0];
  assign expo       = {field[FIELD_W-1:MANT_W+2], field[MANT_W]};
  assign unusedHole = field[MANT_W+1];
  assign legCode    = field[LEG_W-1:0];

  always_comb begin
    extDiv = DIV_W'(mant) << expo;
    if (legCode >= LEG_W'(LEG_OFS + 2))
      legDiv = DIV_W'(legCode - LEG_W'(LEG_OFS)) << 1;
    else
      legDiv = '0;
    rawDiv = extMode ? extDiv : legDiv;
    decDiv = (rawDiv < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : rawDiv;
  end

  // Setting is captured only while idle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          divReg <= DIV_W'(MIN_DIV);
    else if (seq.clear) divReg <= decDiv;
  end

  assign loLen  = divReg >> 1;
  assign hiLen  = divReg - loLen;
  assign curLen = (seq.phase == PH_TO_RISE) ? hiLen : loLen;
  assign terminal = (cnt == curLen - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (seq.clear)   cnt <= '0;
    else if (seq.advance) cnt <= terminal ? '0 : cnt + DIV_W'(1);
  end

  AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    divReg >= DIV_W'(MIN_DIV)) else $error("divisor below floor"); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt < curLen) else $error("count past half length"); // R8
  AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!seq.clear && $past(!seq.clear)) |-> $stable(divReg)) else $error("setting moved mid-run"); // R10

endmodule

// File: rtl/sck_div_ctrl.sv
`timescale 1ns/1ps
module sck_div_ctrl
  import sck_div_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic runEn,
  input  logic terminal,
  output seq_t seq,
  output logic riseStb,
  output logic fallStb
);

  phase_e phase;

  assign seq.clear   = !runEn;
  assign seq.advance = runEn;
  assign seq.phase   = phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_TO_RISE;
      riseStb <= 1'b0;
      fallStb <= 1'b0;
    end else if (!runEn) begin
      phase   <= PH_TO_RISE;
      riseStb <= 1'b0;
      fallStb <= 1'b0;
    end else begin
      riseStb <= terminal && (phase == PH_TO_RISE);
      fallStb <= terminal && (phase == PH_TO_FALL);
      if (terminal)
        phase <= (phase == PH_TO_RISE) ? PH_TO_FALL : PH_TO_RISE;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(riseStb && fallStb)) else $error("both strobes high"); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (!riseStb && !fallStb)) else $error("strobe while idle"); // R2
  AST_RISE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    riseStb |=> !riseStb) else $error("back-to-back rise"); // R8
  AST_FALL_GAP: assert property (@(posedge clk) disable iff (!rstN)
    fallStb |=> !fallStb) else $error("back-to-back fall"); // R8

endmodule

// File: rtl/sck_prescaler.sv
`timescale 1ns/1ps
module sck_prescaler
  import sck_div_pkg::*;
#(
  parameter int MANT_W  = 4,
  parameter int EXP_W   = 3,
  parameter int LEG_W   = 5,
  parameter int LEG_OFS = 16,
  parameter int MIN_DIV = 4,
  localparam int FIELD_W = MANT_W + EXP_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               runEn,
  input  logic               extMode,
  input  logic [FIELD_W-1:0] prescaleField,
  output logic               riseStb,
  output logic               fallStb
);

  seq_t seq;
  logic terminal;

  sck_div_path #(
    .MANT_W(MANT_W), .EXP_W(EXP_W), .LEG_W(LEG_W),
    .LEG_OFS(LEG_OFS), .MIN_DIV(MIN_DIV)
  ) uPath (
    .clk(clk), .rstN(rstN), .extMode(extMode),
    .field(prescaleField), .seq(seq), .terminal(terminal)
  );

  sck_div_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .terminal(terminal),
    .seq(seq), .riseStb(riseStb), .fallStb(fallStb)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $rose(rstN) |-> (!riseStb && !fallStb)) else $error("strobe out of reset"); // R1

endmodule

// File: tb/tb_sck_prescaler.sv
`timescale 1ns/1ps
module tb_sck_prescaler;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       runEn = 1'b0;
  logic       extMode = 1'b0;
  logic [7:0] field = 8'h00;
  logic       riseStb, fallStb;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  sck_prescaler dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .extMode(extMode),
    .prescaleField(field), .riseStb(riseStb), .fallStb(fallStb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Divisor from the requirement text (R3, R5, R6, R7).
  function automatic int expDiv(input logic [7:0] f, input logic ext);
    int d, m, e, code;
    if (ext) begin
      m = int'(f & 8'h0F);
      e = int'((f >> 4) & 8'h01) + 2 * int'((f >> 6) & 8'h03);
      d = (m == 0) ? 4 : m * (1 << e);
    end else begin
      code = int'(f & 8'h1F);
      d = (code < 18) ? 4 : 2 * (code - 16);
    end
    if (d < 4) d = 4;
    return d;
  endfunction

  task automatic runCheck(input logic [7:0] f, input logic ext, input string req,
                          input bit midChange, input logic [7:0] f2, input logic ext2);
    int d, h, l, r1, f1, r2, both;
    d = expDiv(f, ext); l = d / 2; h = d - l;
    r1 = -1; f1 = -1; r2 = -1; both = 0;
    @(negedge clk); field = f; extMode = ext;
    @(negedge clk); runEn = 1'b1;
    for (int e = 1; e <= h + d + 1; e++) begin
      @(posedge clk); #1;
      if (riseStb) begin
        if (r1 < 0) r1 = e; else if (r2 < 0) r2 = e;
      end
      if (fallStb && f1 < 0) f1 = e;
      if (riseStb && fallStb) both++;
      if (midChange && e == 1) begin
        @(negedge clk); field = f2; extMode = ext2;
      end
    end
    chk(r1 == h, {req, " first rise (R9)"}, r1, h);
    chk(f1 == h + l, {req, " first fall (R8)"}, f1, h + l);
    chk(r2 == h + d, {req, " period"}, r2, h + d);
    chk(both == 0, "R12 exclusive strobes", both, 0);
    @(negedge clk); runEn = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int quiet;
    logic [7:0] rf;
    logic re;
    void'($urandom(32'd4242));

    // R1: reset state
    repeat (3) @(posedge clk);
    #1 chk(!riseStb && !fallStb, "R1 during reset", int'(riseStb) + int'(fallStb), 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1
    chk(!riseStb && !fallStb, "R1 after reset", int'(riseStb) + int'(fallStb), 0);

    // R2: idle with a valid setting, no strobes
    @(negedge clk); field = 8'h12; extMode = 1'b0;
    quiet = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      if (riseStb || fallStb) quiet++;
    end
    chk(quiet == 0, "R2 idle quiet", quiet, 0);

    // Directed corner cases
    runCheck(8'h00, 1'b1, "R6 ext mantissa 0", 0, 8'h00, 1'b0);
    runCheck(8'h10, 1'b1, "R6 ext mantissa 0 with exponent", 0, 8'h00, 1'b0);
    runCheck(8'h00, 1'b0, "R6 legacy 0x00", 0, 8'h00, 1'b0);
    runCheck(8'h11, 1'b0, "R6 legacy 0x11", 0, 8'h00, 1'b0);
    runCheck(8'h12, 1'b0, "R5 legacy 0x12", 0, 8'h00, 1'b0);
    runCheck(8'h1F, 1'b0, "R5 legacy 0x1F", 0, 8'h00, 1'b0);
    runCheck(8'hF5, 1'b0, "R5 legacy upper bits ignored", 0, 8'h00, 1'b0);
    runCheck(8'h01, 1'b1, "R7 ext 1 clamp", 0, 8'h00, 1'b0);
    runCheck(8'h02, 1'b1, "R7 ext 2 clamp", 0, 8'h00, 1'b0);
    runCheck(8'h05, 1'b1, "R8 odd divisor 5", 0, 8'h00, 1'b0);
    runCheck(8'h25, 1'b1, "R4 hole bit set", 0, 8'h00, 1'b0);
    runCheck(8'h13, 1'b1, "R3 exponent bit 4", 0, 8'h00, 1'b0);
    runCheck(8'h43, 1'b1, "R3 exponent bit 6", 0, 8'h00, 1'b0);
    runCheck(8'h83, 1'b1, "R3 exponent bit 7", 0, 8'h00, 1'b0);
    runCheck(8'hDF, 1'b1, "R3 max 1920", 0, 8'h00, 1'b0);
    runCheck(8'hFF, 1'b1, "R4 max with hole bit", 0, 8'h00, 1'b0);

    // R10: change the setting mid-run, timing must follow the old one
    runCheck(8'h13, 1'b0, "R10 mid-run change", 1, 8'h0F, 1'b1);
    runCheck(8'h0F, 1'b1, "R10 new setting after idle", 0, 8'h00, 1'b0);

    // R11: abort after the first rise, then restart
    @(negedge clk); field = 8'h05; extMode = 1'b1;
    @(negedge clk); runEn = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); runEn = 1'b0;
    quiet = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      if (riseStb || fallStb) quiet++;
    end
    chk(quiet == 0, "R11 abort quiet", quiet, 0);
    runCheck(8'h05, 1'b1, "R11 restart from rise", 0, 8'h00, 1'b0);

    // Random settings in both modes
    for (int t = 0; t < 30; t++) begin
      rf = 8'($urandom());
      re = 1'($urandom());
      runCheck(rf, re, re ? "R3 random ext" : "R5 random legacy", 0, 8'h00, 1'b0);
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule